// File: doc/BRIEF.md
# Echo Instruction Fetch Sequencer

This block owns the fetch program counter of a small in-order processor whose instruction set includes an echo instruction. An echo names a run of code that already exists earlier in the program. The run is given by a backward byte distance and an instruction count. The sequencer does not copy the code. It sends fetch back to the earlier run, lets the given number of instructions be fetched from there, and then returns fetch to the word after the echo.

The hardware cost is two dedicated registers and one small piece of logic. One register keeps the return address. The other keeps the number of instructions still to replay. The logic is a decrementer whose result feeds a NOR zero test. An echo therefore costs two control transfers: one jump into the earlier code and one jump back. Each cycle the pipeline reports whether it fetched the word at `pc_o`. When that word decodes as an echo, the pipeline also presents the echo's operands in the same cycle. The block answers at once with the next fetch address and a redirect flag.

Top module: `echo_fetch_seq`

## Requirements
- R1: A synchronous reset places `pc_o` at the parameter `RESET_VEC`, clears the replay count and drives `busy_o` low.
- R2: When idle, a fetch with no echo request gives `npc_o = pc_o + 4` with `redir_o` low. A cycle with `adv_i` low keeps `pc_o` unchanged on the next cycle and gives `npc_o = pc_o`.
- R3: An accepted echo gives `npc_o = pc_o - echo_off_i` and raises `redir_o` in the same cycle. An echo is accepted when `adv_i` is high, `echo_req_i` is high, the block is idle and `echo_cnt_i` is nonzero. The offset is in bytes, and `busy_o` is high from the next cycle.
- R4: During a replay, the k-th replayed fetch (k counted from 0) is at target + 4k, and `busy_o` stays high until the last replayed fetch has been taken.
- R5: On the N-th replayed fetch, `npc_o` equals the echo's own address + 4 and `redir_o` is high. After that fetch `busy_o` is low and `pc_o` holds the return address. This also holds for N = 1.
- R6: An echo with a count of zero does nothing: `npc_o = pc_o + 4`, `redir_o` stays low and `busy_o` stays low.
- R7: An echo request that arrives while busy raises `err_o` in that cycle. It is otherwise ignored: the fetch counts as an ordinary replayed instruction, `npc_o = pc_o + 4`, and the return address does not change.
- R8: A cycle with `adv_i` low during a replay neither advances the PC nor consumes any of the replay count.
- R9: The largest count, 2^CW - 1, replays exactly that many instructions before the return.
- R10: All address arithmetic wraps modulo 2^AW, both for the target (PC minus offset) and for sequential steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | The word at `pc_o` is fetched this cycle |
| echo_req_i | input | 1 | The word fetched this cycle is an echo |
| echo_off_i | input | AW | Backward byte distance to the replayed run |
| echo_cnt_i | input | CW | Number of instructions to replay |
| pc_o | output | AW | Current fetch address |
| npc_o | output | AW | Fetch address for the next cycle |
| redir_o | output | 1 | `npc_o` is a non-sequential transfer |
| busy_o | output | 1 | A replay is in progress |
| err_o | output | 1 | Echo request rejected because a replay is in progress |

## Verification
The bench builds the block with AW = 16, CW = 4 and RESET_VEC = 16'h0100. A 4-bit count makes the largest replay, 15 instructions, short enough to step through completely, which covers R9. A 16-bit address space lets an offset larger than the current PC wrap the target below zero, which covers R10. The replays also cover a stall in the middle of a replay, a rejected nested echo, a zero count and a single-instruction replay.

// File: rtl/echo_seq_pkg.sv
package echo_seq_pkg;
  // byte step between sequential instruction words
  localparam int unsigned INSTR_BYTES = 4;

  // source of the next fetch address
  typedef enum logic [1:0] {
    SEL_HOLD   = 2'd0,
    SEL_SEQ    = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_HOME   = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/echo_count_unit.sv
module echo_count_unit #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          idle_o,
  output logic          exhaust_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dec_val;

  assign dec_val   = cnt_q - CW'(1);
  // NOR zero tests: on the held count and on the decremented count
  assign idle_o    = ~|cnt_q;
  assign exhaust_o = ~|dec_val;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (dec_i && !idle_o) cnt_q <= dec_val;
  end
endmodule

// File: rtl/echo_return_reg.sv
module echo_return_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] ret_o
);
  always_ff @(posedge clk) begin
    if (rst)        ret_o <= '0;
    else if (cap_i) ret_o <= addr_i;
  end
endmodule

// File: rtl/echo_pc_select.sv
module echo_pc_select
  import echo_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  pc_sel_e       sel_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] off_i,
  input  logic [AW-1:0] ret_i,
  output logic [AW-1:0] npc_o,
  output logic          redir_o
);
  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] a);
    return a + AW'(INSTR_BYTES);
  endfunction

  function automatic logic [AW-1:0] back_addr(input logic [AW-1:0] a,
                                              input logic [AW-1:0] d);
    return a - d;
  endfunction

  always_comb begin
    unique case (sel_i)
      SEL_SEQ:    npc_o = seq_addr(pc_i);
      SEL_TARGET: npc_o = back_addr(pc_i, off_i);
      SEL_HOME:   npc_o = ret_i;
      default:    npc_o = pc_i;
    endcase
    redir_o = (sel_i == SEL_TARGET) || (sel_i == SEL_HOME);
  end
endmodule

// File: rtl/echo_fetch_seq.sv
module echo_fetch_seq
  import echo_seq_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            CW        = 8,
  parameter logic [AW-1:0] RESET_VEC = AW'(32'h0000_1000)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic          echo_req_i,
  input  logic [AW-1:0] echo_off_i,
  input  logic [CW-1:0] echo_cnt_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic          redir_o,
  output logic          busy_o,
  output logic          err_o
);
  // named internal events
  logic    idle;
  logic    exhaust;
  logic    take_echo;
  logic    nested_echo;
  logic    last_replay;
  logic    count_fetch;
  pc_sel_e sel;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] pc_q;

  assign take_echo   = adv_i && echo_req_i && idle && (|echo_cnt_i);
  assign nested_echo = adv_i && echo_req_i && !idle;
  assign count_fetch = adv_i && !idle;
  assign last_replay = count_fetch && exhaust;

  always_comb begin
    if (take_echo)        sel = SEL_TARGET;
    else if (last_replay) sel = SEL_HOME;
    else if (adv_i)       sel = SEL_SEQ;
    else                  sel = SEL_HOLD;
  end

  echo_count_unit #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (take_echo),
    .load_val_i (echo_cnt_i),
    .dec_i      (count_fetch),
    .idle_o     (idle),
    .exhaust_o  (exhaust)
  );

  echo_return_reg #(.AW(AW)) u_ret (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (take_echo),
    .addr_i (pc_q + AW'(INSTR_BYTES)),
    .ret_o  (ret_addr)
  );

  echo_pc_select #(.AW(AW)) u_sel (
    .sel_i   (sel),
    .pc_i    (pc_q),
    .off_i   (echo_off_i),
    .ret_i   (ret_addr),
    .npc_o   (npc_o),
    .redir_o (redir_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_VEC;
    else     pc_q <= npc_o;
  end

  assign pc_o   = pc_q;
  assign busy_o = !idle;
  assign err_o  = nested_echo;
endmodule

// File: rtl/echo_fetch_seq_chk.sv
module echo_fetch_seq_chk #(
  parameter int            AW        = 32,
  parameter int            CW        = 8,
  parameter logic [AW-1:0] RESET_VEC = AW'(32'h0000_1000)
) (
  input logic          clk,
  input logic          rst,
  input logic          adv_i,
  input logic          echo_req_i,
  input logic [AW-1:0] echo_off_i,
  input logic [CW-1:0] echo_cnt_i,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] npc_o,
  input logic          redir_o,
  input logic          busy_o,
  input logic          err_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_o == RESET_VEC) && !busy_o);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(pc_o));

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !busy_o && !echo_req_i) |-> (npc_o == pc_o + AW'(4)) && !redir_o);

  a_r3_jump_back: assert property (@(posedge clk) disable iff (rst)
    (adv_i && echo_req_i && !busy_o && (echo_cnt_i != '0))
      |-> redir_o && (npc_o == pc_o - echo_off_i));

  a_r4_busy_after_jump: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && redir_o) |=> busy_o);

  a_r5_home_ends_replay: assert property (@(posedge clk) disable iff (rst)
    (busy_o && redir_o) |=> !busy_o);

  a_r6_zero_count_noop: assert property (@(posedge clk) disable iff (rst)
    (adv_i && echo_req_i && !busy_o && (echo_cnt_i == '0))
      |-> !redir_o && (npc_o == pc_o + AW'(4)));

  a_r7_nested_flagged: assert property (@(posedge clk) disable iff (rst)
    err_o |-> busy_o && adv_i && echo_req_i);

  a_r8_stall_keeps_busy: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && busy_o) |=> busy_o);

  a_r2_redirect_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    redir_o |-> adv_i);
endmodule

bind echo_fetch_seq echo_fetch_seq_chk #(
  .AW(AW), .CW(CW), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .adv_i      (adv_i),
  .echo_req_i (echo_req_i),
  .echo_off_i (echo_off_i),
  .echo_cnt_i (echo_cnt_i),
  .pc_o       (pc_o),
  .npc_o      (npc_o),
  .redir_o    (redir_o),
  .busy_o     (busy_o),
  .err_o      (err_o)
);

// File: tb/echo_fetch_seq_bench.sv
`timescale 1ns/1ps
module echo_fetch_seq_bench;
  localparam int            AW  = 16;
  localparam int            CW  = 4;
  localparam logic [AW-1:0] VEC = 16'h0100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          adv_i = 1'b0;
  logic          echo_req_i = 1'b0;
  logic [AW-1:0] echo_off_i = '0;
  logic [CW-1:0] echo_cnt_i = '0;
  logic [AW-1:0] pc_o, npc_o;
  logic          redir_o, busy_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  echo_fetch_seq #(.AW(AW), .CW(CW), .RESET_VEC(VEC)) u_echo_fetch_seq (
    .clk(clk), .rst(rst), .adv_i(adv_i), .echo_req_i(echo_req_i),
    .echo_off_i(echo_off_i), .echo_cnt_i(echo_cnt_i), .pc_o(pc_o),
    .npc_o(npc_o), .redir_o(redir_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // set inputs after the falling edge, let combinational outputs settle
  task automatic drive(input logic a, input logic e, input logic [AW-1:0] off,
                       input logic [CW-1:0] cnt);
    @(negedge clk);
    adv_i = a; echo_req_i = e; echo_off_i = off; echo_cnt_i = cnt;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    check("R1 pc", 32'(pc_o), 32'(VEC));
    check("R1 busy", 32'(busy_o), 0);
  endtask

  task automatic t_sequential();
    logic [AW-1:0] p;
    p = pc_o;
    for (int i = 0; i < 3; i++) begin
      drive(1, 0, '0, '0);
      check("R2 npc", 32'(npc_o), 32'(AW'(p + AW'(4 * (i + 1)))));
      check("R2 redir", 32'(redir_o), 0);
    end
    drive(0, 0, '0, '0);
    check("R2 pc after fetches", 32'(pc_o), 32'(AW'(p + 16'd12)));
    check("R2 stall npc", 32'(npc_o), 32'(pc_o));
    drive(0, 0, '0, '0);
    check("R2 stall pc", 32'(pc_o), 32'(AW'(p + 16'd12)));
  endtask

  // full replay: stall_at / nest_at pick a replay index, -1 for none
  task automatic t_echo(input string tag, input logic [AW-1:0] off, input int n,
                        input int stall_at, input int nest_at);
    logic [AW-1:0] home, tgt;
    home = pc_o;
    tgt  = home - off;
    drive(1, 1, off, CW'(n));
    check({tag, " R3 target"}, 32'(npc_o), 32'(tgt));
    check({tag, " R3 redir"}, 32'(redir_o), 1);
    for (int i = 0; i < n; i++) begin
      if (i == stall_at) begin
        drive(0, 0, '0, '0);
        check({tag, " R8 stall pc"}, 32'(pc_o), 32'(AW'(tgt + AW'(4 * i))));
        check({tag, " R8 stall busy"}, 32'(busy_o), 1);
        drive(0, 0, '0, '0);
        check({tag, " R8 stall held"}, 32'(pc_o), 32'(AW'(tgt + AW'(4 * i))));
      end
      drive(1, i == nest_at, 16'h0040, 4'd2);
      check({tag, " R4 replay pc"}, 32'(pc_o), 32'(AW'(tgt + AW'(4 * i))));
      check({tag, " R4 busy"}, 32'(busy_o), 1);
      check({tag, " R7 err"}, 32'(err_o), 32'(i == nest_at));
      if (i == n - 1) begin
        check({tag, " R5 home"}, 32'(npc_o), 32'(AW'(home + 16'd4)));
        check({tag, " R5 redir"}, 32'(redir_o), 1);
      end else begin
        check({tag, " R4/R7 seq"}, 32'(npc_o), 32'(AW'(pc_o + 16'd4)));
        check({tag, " R4/R7 no redir"}, 32'(redir_o), 0);
      end
    end
    drive(0, 0, '0, '0);
    check({tag, " R5 busy low"}, 32'(busy_o), 0);
    check({tag, " R5 pc home"}, 32'(pc_o), 32'(AW'(home + 16'd4)));
  endtask

  task automatic t_zero_count();
    logic [AW-1:0] p;
    p = pc_o;
    drive(1, 1, 16'h0010, '0);
    check("R6 npc", 32'(npc_o), 32'(AW'(p + 16'd4)));
    check("R6 redir", 32'(redir_o), 0);
    drive(0, 0, '0, '0);
    check("R6 busy", 32'(busy_o), 0);
    check("R6 pc", 32'(pc_o), 32'(AW'(p + 16'd4)));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequential();
    t_echo("basic", 16'h0010, 3, -1, -1);
    t_echo("stall+nest", 16'h0008, 4, 2, 1);
    t_zero_count();
    t_echo("R9 max", 16'h0040, 15, -1, -1);
    t_echo("R10 wrap", 16'h0400, 1, -1, -1);
    t_echo("R10 wrap back", 16'hFF00, 2, -1, -1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule